// File: doc/BRIEF.md
# Four-Channel Converter Code Register Bank

This block is a register front end for a bank of 12-bit digital-to-analog converter channels. A 32-bit bus writes and reads a control word and a data word for each channel in a single cycle. The block then drives each channel's converter with a 12-bit code, a 2-bit output range and an output-enable. The analog side is outside the block: the converter, its reference selection and its output amplifier.

Each channel keeps two values. The first is the data register, which holds the code last written from the bus. The second is a separate active code, which is what the converter sees. A control bit picks when the data register moves into the active code. In direct mode it follows on every clock. In tick mode it moves only on a pulse from an external timer, so software can load a new value early and have it take effect on a precise event. A second control bit is an active-low clear. While that bit is low, the data register and the active code are both held at zero.

Top module: `dacreg_top`

## Requirements
- R1: Channel n has its control word at byte offset 8*n and its data word at byte offset 8*n+4, for n from 0 to 3. After reset, every register reads 0.
- R2: In the data word, the 12-bit code sits in bits 27:16. Bits 31:28 and 15:0 read as 0, and writing them has no effect.
- R3: In the control word, bit 5 selects tick mode (1) or direct mode (0), bit 4 is the active-low clear, and bits 1:0 are the range. All other bits read as 0, and writing them has no effect.
- R4: In direct mode with the clear bit high, the active code on `ch_code` equals the data register one clock after the data register changes.
- R5: In tick mode, writing the data word changes the data word's read-back at once but leaves the active code unchanged. The active code takes the data register value at the clock edge where `tmr_tick` is high.
- R6: While the clear bit is 0, the data word reads 0 and writes to it are ignored. In either mode, the active code goes to 0 at the same edge as the control write that sets clear to 0.
- R7: `ch_range` shows the channel's range field. The channel's `ch_oe` bit is 0 exactly when the range is 00. The active code is kept while the range is 00, and the same code comes back when a non-zero range is selected again.
- R8: An access to any address that is not a register reads as 0 and changes no register. This includes offsets past 0x1C and addresses that are not 4-byte aligned.
- R9: After reset, all channel outputs are 0: code, range and output-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tmr_tick | input | 1 | One-cycle timer pulse, used by channels in tick mode |
| ch_code | output | 48 | Active 12-bit code per channel; channel n in bits 12n+11:12n |
| ch_range | output | 8 | Range field per channel; channel n in bits 2n+1:2n |
| ch_oe | output | 4 | Output-enable per channel, low in power-down |

## Verification
The assertions assume a bus write reaches at most one register per cycle. They also assume `tmr_tick` is a clean single-cycle level sampled at the clock. The stimulus drives every input at the falling edge and holds it for one full cycle, so no write or tick pulse is ever cut short. The bench sweeps every channel through every mode and range with a distinct code each time. It also reads the whole 8-bit address space after reset and writes all-ones to unmapped and misaligned addresses. A model kept in the bench predicts every read-back and output value.

// File: rtl/dacreg_pkg.sv
// Shared field positions and types for the converter code register bank.
// Assumes a 32-bit bus; the bit positions are fixed by the register layout.
package dacreg_pkg;
    localparam int BUS_W     = 32;
    localparam int MODE_BIT  = 5;
    localparam int CLRN_BIT  = 4;
    localparam int RANGE_LSB = 0;
    localparam int RANGE_W   = 2;
    localparam int CODE_LSB  = 16;

    typedef enum logic [RANGE_W-1:0] {
        RNG_OFF    = 2'b00,
        RNG_EXTREF = 2'b01,
        RNG_INT25  = 2'b10,
        RNG_SUPPLY = 2'b11
    } range_e;

    typedef struct packed {
        logic   upd_on_tick;
        logic   clr_n;
        range_e range;
    } chan_ctrl_t;

    // Builds the bus image of a control word, with reserved bits at zero.
    function automatic logic [BUS_W-1:0] ctrl_image(chan_ctrl_t c);
        logic [BUS_W-1:0] r;
        r = '0;
        r[MODE_BIT] = c.upd_on_tick;
        r[CLRN_BIT] = c.clr_n;
        r[RANGE_LSB +: RANGE_W] = c.range;
        return r;
    endfunction
endpackage

// File: rtl/dacreg_decode.sv
// Address decoder: gives one select line per control word and per data word.
// Assumes byte addresses; only aligned words at 8*n and 8*n+4 match.
module dacreg_decode #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ctrl_sel,
    output logic [NUM_CH-1:0] data_sel
);
    // Compares the address against each channel's two register offsets.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            ctrl_sel[i] = (addr == ADDR_W'(8 * i));
            data_sel[i] = (addr == ADDR_W'(8 * i + 4));
        end
    end

    // At most one register is selected by any address (R1).
    assert_single_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_sel, data_sel}));
endmodule

// File: rtl/dacreg_channel.sv
// One converter channel: control word, data register and active code.
// Assumes at most one of ctrl_we/data_we in a cycle; tick is one clock wide.
module dacreg_channel
    import dacreg_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              data_we,
    input  chan_ctrl_t        wr_ctrl,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              tick,
    output chan_ctrl_t        ctrl_q,
    output logic [CODE_W-1:0] data_q,
    output logic [CODE_W-1:0] active_q
);
    logic clr_n_d;
    logic mode_d;

    // Control values that hold after this edge, so a clear acts at once.
    always_comb begin
        clr_n_d = ctrl_we ? wr_ctrl.clr_n       : ctrl_q.clr_n;
        mode_d  = ctrl_we ? wr_ctrl.upd_on_tick : ctrl_q.upd_on_tick;
    end

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wr_ctrl;
    end

    // Data register; forced to zero while the clear bit is low.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (!clr_n_d) data_q <= '0;
        else if (data_we) data_q <= wr_code;
    end

    // Active code; follows the data register every clock or on a tick only.
    always_ff @(posedge clk) begin
        if (!rst_n)                 active_q <= '0;
        else if (!clr_n_d)          active_q <= '0;
        else if (!mode_d || tick)   active_q <= data_q;
    end

    // A low clear bit means both held values are zero (R6).
    assert_clear_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.clr_n |-> (data_q == '0 && active_q == '0));

    // Tick mode without a tick keeps the active code (R5).
    assert_tick_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_d && mode_d && !tick) |=> $stable(active_q));

    // Direct mode copies the data register one clock later (R4).
    assert_direct_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_d && !mode_d) |=> (active_q == $past(data_q)));
endmodule

// File: rtl/dacreg_top.sv
// Register bank for NUM_CH converter channels on a 32-bit bus.
// Assumes single-cycle accesses; reads are combinational and side-effect free.
module dacreg_top
    import dacreg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BUS_W-1:0]         bus_wdata,
    output logic [BUS_W-1:0]         bus_rdata,
    input  logic                     tmr_tick,
    output logic [NUM_CH*CODE_W-1:0] ch_code,
    output logic [NUM_CH*RANGE_W-1:0] ch_range,
    output logic [NUM_CH-1:0]        ch_oe
);
    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

    logic [NUM_CH-1:0] ctrl_sel;
    logic [NUM_CH-1:0] data_sel;
    chan_ctrl_t        wr_ctrl;
    logic [CODE_W-1:0] wr_code;
    chan_ctrl_t        ctrl_q   [NUM_CH];
    logic [CODE_W-1:0] data_q   [NUM_CH];
    logic [CODE_W-1:0] active_q [NUM_CH];
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata;

    // Pulls the writable fields out of the bus word.
    always_comb begin
        wr_ctrl.upd_on_tick = bus_wdata[MODE_BIT];
        wr_ctrl.clr_n       = bus_wdata[CLRN_BIT];
        wr_ctrl.range       = range_e'(bus_wdata[RANGE_LSB +: RANGE_W]);
        wr_code             = bus_wdata[CODE_MSB:CODE_LSB];
    end

    dacreg_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .ctrl_sel (ctrl_sel),
        .data_sel (data_sel)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dacreg_channel #(.CODE_W(CODE_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (bus_wr && ctrl_sel[g]),
            .data_we  (bus_wr && data_sel[g]),
            .wr_ctrl  (wr_ctrl),
            .wr_code  (wr_code),
            .tick     (tmr_tick),
            .ctrl_q   (ctrl_q[g]),
            .data_q   (data_q[g]),
            .active_q (active_q[g])
        );
        assign ch_code[g*CODE_W +: CODE_W]    = active_q[g];
        assign ch_range[g*RANGE_W +: RANGE_W] = ctrl_q[g].range;
        assign ch_oe[g]                       = (ctrl_q[g].range != RNG_OFF);
    end

    // Read mux: ORs in the image of the selected register, zero otherwise.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ctrl_sel[i]) bus_rdata = bus_rdata | ctrl_image(ctrl_q[i]);
            if (data_sel[i]) bus_rdata[CODE_MSB:CODE_LSB] = bus_rdata[CODE_MSB:CODE_LSB] | data_q[i];
        end
    end

    // Unmapped addresses read as zero (R8).
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|{ctrl_sel, data_sel}) |-> (bus_rdata == '0));

    // Reserved data-word bits never read as one (R2).
    assert_data_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|data_sel) |-> (bus_rdata[BUS_W-1:CODE_MSB+1] == '0 && bus_rdata[CODE_LSB-1:0] == '0));

    // Reserved control-word bits never read as one (R3).
    assert_ctrl_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctrl_sel) |-> (bus_rdata[BUS_W-1:MODE_BIT+1] == '0 && bus_rdata[CLRN_BIT-1:RANGE_W] == '0));
endmodule

// File: tb/tb_dacreg_top.sv
// Self-checking bench: address sweep, mode/range sweep, clear, power-down, unmapped.
module tb_dacreg_top;
    localparam int CLK_PER = 10;
    localparam int NCH = 4;
    localparam int CW  = 12;
    localparam int AW  = 8;

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, tmr_tick = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    wire  [31:0] bus_rdata;
    wire  [NCH*CW-1:0] ch_code;
    wire  [NCH*2-1:0] ch_range;
    wire  [NCH-1:0] ch_oe;

    int n_checks = 0, n_errors = 0;
    bit m_mode [NCH];
    bit m_clr  [NCH];
    logic [1:0]  m_rng  [NCH];
    logic [11:0] m_data [NCH];
    logic [11:0] m_act  [NCH];

    dacreg_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_tick(tmr_tick),
        .ch_code(ch_code), .ch_range(ch_range), .ch_oe(ch_oe)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl(int ch);
        return {26'b0, m_mode[ch], m_clr[ch], 2'b00, m_rng[ch]};
    endfunction

    function automatic logic [31:0] exp_data(int ch);
        return {4'b0, m_data[ch], 16'b0};
    endfunction

    // One-cycle write, then the model is updated from R2, R3 and R6.
    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a >= 0 && a < 8 * NCH && a % 4 == 0) begin
            if (a % 8 == 0) begin
                m_mode[a/8] = d[5]; m_clr[a/8] = d[4]; m_rng[a/8] = d[1:0];
                if (!d[4]) begin m_data[a/8] = '0; m_act[a/8] = '0; end
            end else if (m_clr[a/8]) begin
                m_data[a/8] = d[27:16];
            end
        end
    endtask

    // One idle clock: direct-mode channels take their data register (R4).
    task automatic settle();
        @(negedge clk);
        for (int c = 0; c < NCH; c++) if (!m_mode[c]) m_act[c] = m_data[c];
    endtask

    // One tick pulse: every channel takes its data register (R5).
    task automatic tick();
        @(negedge clk); tmr_tick = 1'b1;
        @(negedge clk); tmr_tick = 1'b0;
        for (int c = 0; c < NCH; c++) m_act[c] = m_data[c];
    endtask

    task automatic rd(string req, int a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = AW'(a);
        #(CLK_PER/4);
        check(req, bus_rdata, exp);
    endtask

    task automatic chk_out(string req, int ch);
        check({req, " code"}, 32'(ch_code[ch*CW +: CW]), 32'(m_act[ch]));
        check({req, " range"}, 32'(ch_range[ch*2 +: 2]), 32'(m_rng[ch]));
        check({req, " oe"}, 32'(ch_oe[ch]), 32'(m_rng[ch] != 2'b00));
    endtask

    task automatic chk_all(string req);
        for (int c = 0; c < NCH; c++) begin
            rd({req, " R1 ctrl"}, 8 * c, exp_ctrl(c));
            rd({req, " R1 data"}, 8 * c + 4, exp_data(c));
            chk_out(req, c);
        end
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_mode[c] = 0; m_clr[c] = 0; m_rng[c] = 0; m_data[c] = 0; m_act[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: outputs at zero; R1: whole address space reads zero after reset.
        for (int c = 0; c < NCH; c++) chk_out("R9", c);
        for (int a = 0; a < 256; a++) rd("R1 reset read", a, 32'h0);

        // R2, R3: all-ones writes keep only the defined fields.
        for (int c = 0; c < NCH; c++) begin
            wr(8 * c, 32'hFFFF_FFFF);
            rd("R3 ctrl reserved", 8 * c, 32'h0000_0033);
            wr(8 * c + 4, 32'hFFFF_FFFF);
            rd("R2 data reserved", 8 * c + 4, 32'h0FFF_0000);
            tick();
            chk_out("R2", c);
        end

        // R3, R4, R5, R7: every channel through every mode and range.
        for (int c = 0; c < NCH; c++) begin
            for (int md = 0; md < 2; md++) begin
                for (int rg = 0; rg < 4; rg++) begin
                    logic [11:0] code;
                    code = 12'((c * 977 + md * 331 + rg * 1213 + 5) & 12'hFFF);
                    wr(8 * c, {26'b0, 1'(md), 1'b1, 2'b00, 2'(rg)});
                    rd("R3 ctrl readback", 8 * c, exp_ctrl(c));
                    wr(8 * c + 4, {4'hA, code, 16'hABCD});
                    if (md == 1) begin
                        chk_out("R5 no tick", c);
                        rd("R5 written value", 8 * c + 4, exp_data(c));
                        chk_out("R5 still held", c);
                        tick();
                        chk_out("R5 after tick", c);
                    end else begin
                        chk_out("R4 one clock lag", c);
                        settle();
                        chk_out("R4 follow", c);
                    end
                    chk_out("R7 range", c);
                end
            end
        end

        // R6: clearing in tick mode zeroes the code at once; data writes ignored.
        for (int c = 0; c < NCH; c++) begin
            wr(8 * c, 32'h0000_0031);
            wr(8 * c + 4, 32'h0ABC_0000);
            tick();
            chk_out("R6 before clear", c);
            wr(8 * c, 32'h0000_0021);
            chk_out("R6 immediate clear", c);
            rd("R6 data zero", 8 * c + 4, 32'h0);
            wr(8 * c + 4, 32'h0555_0000);
            rd("R6 write ignored", 8 * c + 4, 32'h0);
            wr(8 * c, 32'h0000_0031);
            tick();
            chk_out("R6 released", c);
            wr(8 * c, 32'h0000_0012);
            wr(8 * c + 4, 32'h0321_0000);
            settle();
            wr(8 * c, 32'h0000_0002);
            chk_out("R6 direct clear", c);
        end

        // R7: power-down keeps the code and restores it afterwards.
        for (int c = 0; c < NCH; c++) begin
            wr(8 * c, 32'h0000_0012);
            wr(8 * c + 4, {4'h0, 12'(c * 700 + 99), 16'h0});
            settle();
            wr(8 * c, 32'h0000_0010);
            chk_out("R7 powered down", c);
            settle();
            wr(8 * c, 32'h0000_0013);
            chk_out("R7 restored", c);
        end

        // R8: unmapped and misaligned writes change nothing.
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h21, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'h06, 32'h0000_0000);
        wr(8'h0B, 32'h0000_0000);
        wr(8'hFC, 32'hFFFF_FFFF);
        settle();
        chk_all("R8");
        rd("R8 unmapped read", 8'h20, 32'h0);
        rd("R8 misaligned read", 8'h05, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule